// File: doc/BRIEF.md
# Selectable Serial Line Code Encoder

This block turns a stream of data bits into a single serial line waveform. Four codings are available: plain level coding, transition-on-one coding, split-phase coding with a mid-bit edge on every bit, and a boundary-toggling biphase code in which a one adds a second edge at mid-bit. Each bit period is split into two halves. An external half-bit enable paces the output, so the line can carry half-bit symbols at twice the bit rate.

A producer offers one bit at a time with a valid signal. The encoder takes the bit on the first half-bit tick of a bit period and signals this with a ready strobe. If no bit is offered at a bit boundary, the line holds its level, the boundary is not used up, and a one-cycle underrun pulse is raised. The coding mode is sampled when a bit is accepted. Software should change it only while the idle output is high. A change in the middle of a bit does not affect the second half of that bit. The codings that depend on history continue from whatever level the line last had, even across mode changes.

Top module: `line_code_enc`

## Requirements
- R1: After reset the line is low, the underrun flag is low and the idle output is high.
- R2: In level mode (mode code 0) a 1 drives the line high and a 0 drives it low for both halves of the bit.
- R3: In transition mode (mode code 1) a 1 inverts the line at the start of the bit and a 0 leaves it unchanged. The level then holds through the second half.
- R4: In split-phase mode (mode code 2) a 1 is sent as low then high, and a 0 as high then low, so every bit has a mid-bit transition.
- R5: In biphase mode (mode code 3) the line toggles at every accepted bit boundary, and toggles again at mid-bit only when the bit is 1.
- R6: Transition mode and biphase mode start from the line's last driven level, including right after a mode change.
- R7: A bit-boundary tick with no valid bit holds the line, raises underrun for exactly one clock, and leaves the encoder idle so that the next tick is again a boundary.
- R8: The line changes only on clocks where the half-bit enable is high. The ready strobe is high only on a boundary tick, which is a tick that arrives while idle is high, and the second tick of each bit is never a boundary.
- R9: The mode is sampled when a bit is accepted. A mode change during the second half of a bit has no effect on that half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Half-bit enable; one pulse per half bit period |
| mode | input | 2 | Coding select: 0 level, 1 transition, 2 split-phase, 3 biphase |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | The offered data bit |
| bit_ready | output | 1 | The offered bit is taken on this clock |
| line_out | output | 1 | Encoded serial line level |
| underrun | output | 1 | One-clock pulse when a boundary tick finds no valid bit |
| idle | output | 1 | No bit in progress; the next tick is a bit boundary |

## Verification
Fixed bit patterns of alternating values, runs of ones and runs of zeros go through each mode. Runs of ones separate the transition code from level coding. Runs of zeros show that biphase still toggles at boundaries while the transition code stays flat. Starting the history-dependent modes from both line levels, and switching modes between bits, shows whether the encoder continues from the line or from a fixed level. A long random stream with irregular tick gaps, missing bits and mode changes at boundaries is compared every clock against a behavioural model. Directed cases also cover a missing bit at a boundary and a mode change in the middle of a bit.

// File: rtl/lce_pkg.sv
package lce_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    CODE_LEVEL  = 2'd0,
    CODE_TRANS  = 2'd1,
    CODE_SPLIT  = 2'd2,
    CODE_BIPH   = 2'd3
  } code_mode_t;

  // Level for the first half of a bit, given the level the line has now.
  function automatic logic lead_level(code_mode_t m, logic d, logic cur);
    logic lv;
    unique case (m)
      CODE_LEVEL: lv = d;
      CODE_TRANS: lv = cur ^ d;
      CODE_SPLIT: lv = ~d;
      default:    lv = ~cur;
    endcase
    return lv;
  endfunction

  // Level for the second half of a bit, given the level of the first half.
  function automatic logic trail_level(code_mode_t m, logic d, logic cur);
    logic lv;
    unique case (m)
      CODE_LEVEL: lv = d;
      CODE_TRANS: lv = cur;
      CODE_SPLIT: lv = d;
      default:    lv = cur ^ d;
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/lce_bit_sched.sv
module lce_bit_sched
  import lce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       bit_valid,
  input  code_mode_t mode_in,
  output logic       bit_ready,
  output logic       accept_ev,
  output logic       mid_ev,
  output logic       starve_ev,
  output logic       idle,
  output code_mode_t held_mode,
  output logic       underrun_q
);

  logic in_bit_q;

  assign idle      = ~in_bit_q;
  assign bit_ready = half_tick & ~in_bit_q;
  assign accept_ev = bit_ready & bit_valid;
  assign starve_ev = bit_ready & ~bit_valid;
  assign mid_ev    = half_tick & in_bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_bit_q   <= 1'b0;
      held_mode  <= CODE_LEVEL;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= starve_ev;
      if (accept_ev) begin
        in_bit_q  <= 1'b1;
        held_mode <= mode_in;
      end else if (mid_ev) begin
        in_bit_q  <= 1'b0;
      end
    end
  end

  assert_starve_keeps_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    starve_ev |=> idle && underrun_q);
  assert_accept_enters_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !idle);
  assert_mid_ends_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mid_ev |=> idle && !underrun_q);
  assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && !accept_ev |=> $stable(held_mode));

endmodule

// File: rtl/lce_level_gen.sv
module lce_level_gen
  import lce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_ev,
  input  logic       mid_ev,
  input  logic       bit_data,
  input  code_mode_t mode_in,
  input  code_mode_t held_mode,
  output logic       line_q
);

  logic data_q;
  logic lead_nxt;
  logic trail_nxt;

  assign lead_nxt  = lead_level(mode_in, bit_data, line_q);
  assign trail_nxt = trail_level(held_mode, data_q, line_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      data_q <= 1'b0;
    end else if (accept_ev) begin
      line_q <= lead_nxt;
      data_q <= bit_data;
    end else if (mid_ev) begin
      line_q <= trail_nxt;
    end
  end

  assert_line_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_ev || mid_ev) |=> $stable(line_q));
  assert_level_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && mode_in == CODE_LEVEL |=> line_q == $past(bit_data));
  assert_trans_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && mode_in == CODE_TRANS |=> line_q == ($past(line_q) ^ $past(bit_data)));
  assert_split_mid_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mid_ev && held_mode == CODE_SPLIT |=> line_q != $past(line_q));
  assert_biph_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && mode_in == CODE_BIPH |=> line_q != $past(line_q));

endmodule

// File: rtl/line_code_enc.sv
module line_code_enc
  import lce_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic [1:0] mode,
  input  logic       bit_valid,
  input  logic       bit_data,
  output logic       bit_ready,
  output logic       line_out,
  output logic       underrun,
  output logic       idle
);

  code_mode_t mode_sel;
  code_mode_t held_mode;
  logic       accept_ev;
  logic       mid_ev;
  logic       starve_ev;

  assign mode_sel = code_mode_t'(mode);

  lce_bit_sched u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .half_tick  (half_tick),
    .bit_valid  (bit_valid),
    .mode_in    (mode_sel),
    .bit_ready  (bit_ready),
    .accept_ev  (accept_ev),
    .mid_ev     (mid_ev),
    .starve_ev  (starve_ev),
    .idle       (idle),
    .held_mode  (held_mode),
    .underrun_q (underrun)
  );

  lce_level_gen u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_ev (accept_ev),
    .mid_ev    (mid_ev),
    .bit_data  (bit_data),
    .mode_in   (mode_sel),
    .held_mode (held_mode),
    .line_q    (line_out)
  );

  assert_underrun_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    starve_ev |=> underrun && $stable(line_out));
  assert_biph_one_mid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mid_ev && held_mode == CODE_BIPH |=> line_out != $past(line_out) || !$past(u_level.data_q));

endmodule

// File: tb/line_code_enc_tb.sv
module line_code_enc_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic half_tick = 1'b0;
  logic [1:0] mode = 2'd0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready, line_out, underrun, idle;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  line_code_enc dut_i (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .mode(mode),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .line_out(line_out), .underrun(underrun), .idle(idle)
  );

  // Behavioural reference: each bit expands to a two-level waveform.
  logic m_line = 1'b0;
  logic m_ur = 1'b0;
  int   m_half = 0;
  logic [1:0] m_wave = 2'b00;
  int   m_mode = 0;

  function automatic logic [1:0] wave_of(int md, logic d, logic prev);
    case (md)
      0: return {d, d};
      1: return {prev ^ d, prev ^ d};
      2: return {~d, d};
      default: return {~prev, ~prev ^ d};
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = 1'b0; m_ur = 1'b0; m_half = 0; m_mode = 0;
    end else begin
      m_ur = 1'b0;
      if (half_tick) begin
        if (m_half == 0) begin
          if (bit_valid) begin
            m_mode = int'(mode);
            m_wave = wave_of(m_mode, bit_data, m_line);
            m_line = m_wave[1];
            m_half = 1;
          end else begin
            m_ur = 1'b1;
          end
        end else begin
          m_line = m_wave[0];
          m_half = 0;
        end
      end
    end
  end

  function automatic string mode_req(int md);
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(mode_req(m_mode), "line_out vs model", line_out, m_line);
      check("R7", "underrun vs model", underrun, m_ur);
      check("R8", "idle vs model", idle, m_half == 0);
      check("R8", "bit_ready vs model", bit_ready, half_tick && m_half == 0);
    end
  end

  task automatic idle_cyc(int n);
    repeat (n) begin
      @(negedge clk); #1;
      half_tick = 1'b0; bit_valid = 1'b0;
    end
  endtask

  // One half-bit tick after gap quiet cycles; returns just after the edge.
  task automatic tick(logic v, logic d, int gap);
    idle_cyc(gap);
    @(negedge clk); #1;
    half_tick = 1'b1; bit_valid = v; bit_data = d;
    @(negedge clk); #1;
    half_tick = 1'b0; bit_valid = 1'b0;
  endtask

  task automatic send(logic d, int gap);
    tick(1'b1, d, gap);
    tick(1'b0, 1'b0, gap);
  endtask

  logic p;

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", "line after reset", line_out, 1'b0);
    check("R1", "underrun after reset", underrun, 1'b0);
    check("R1", "idle after reset", idle, 1'b1);
    rst_n = 1'b1;
    idle_cyc(2);

    // R2 level mode
    mode = 2'd0;
    tick(1'b1, 1'b1, 1);
    check("R2", "level 1 first half", line_out, 1'b1);
    tick(1'b0, 1'b0, 0);
    check("R2", "level 1 second half", line_out, 1'b1);
    send(1'b0, 0);
    check("R2", "level 0", line_out, 1'b0);
    send(1'b1, 2);

    // R7 missing bit at a boundary
    tick(1'b0, 1'b0, 1);
    check("R7", "underrun pulse", underrun, 1'b1);
    check("R7", "line held", line_out, 1'b1);
    check("R7", "still idle", idle, 1'b1);
    idle_cyc(1);
    check("R7", "underrun one clock", underrun, 1'b0);
    @(negedge clk); #1;
    half_tick = 1'b1; bit_valid = 1'b1; bit_data = 1'b0;
    #2;
    check("R8", "ready at boundary", bit_ready, 1'b1);
    @(negedge clk); #1;
    half_tick = 1'b1; bit_valid = 1'b1;
    #2;
    check("R8", "no ready on second half", bit_ready, 1'b0);
    @(negedge clk); #1;
    half_tick = 1'b0; bit_valid = 1'b0;
    check("R7", "next tick was a boundary", line_out, 1'b0);

    // R3 transition mode from current level
    mode = 2'd1;
    p = line_out;
    send(1'b1, 0); send(1'b1, 1); send(1'b0, 0); send(1'b1, 2);
    check("R3", "transition run 1101", line_out, ~p);

    // R6 biphase continues from last level
    mode = 2'd3;
    p = line_out;
    tick(1'b1, 1'b0, 0);
    check("R6", "biphase 0 first half from last level", line_out, ~p);
    tick(1'b0, 1'b0, 0);
    check("R5", "biphase 0 no mid edge", line_out, ~p);
    tick(1'b1, 1'b1, 1);
    check("R5", "biphase 1 boundary edge", line_out, p);
    tick(1'b0, 1'b0, 1);
    check("R5", "biphase 1 mid edge", line_out, ~p);

    // R4 split-phase
    mode = 2'd2;
    tick(1'b1, 1'b1, 0);
    check("R4", "split 1 first half low", line_out, 1'b0);
    tick(1'b0, 1'b0, 0);
    check("R4", "split 1 second half high", line_out, 1'b1);
    tick(1'b1, 1'b0, 1);
    check("R4", "split 0 first half high", line_out, 1'b1);
    tick(1'b0, 1'b0, 1);
    check("R4", "split 0 second half low", line_out, 1'b0);

    // R9 mode change in mid bit: biphase 1 with the mode moved to transition
    mode = 2'd3;
    p = line_out;
    tick(1'b1, 1'b1, 0);
    mode = 2'd1;
    tick(1'b0, 1'b0, 1);
    check("R9", "second half uses sampled mode", line_out, p);

    // Random stream, model compared on every clock
    for (int i = 0; i < 600; i++) begin
      int g;
      g = int'($urandom_range(0, 2));
      if (idle && ($urandom_range(0, 7) == 0)) mode = 2'($urandom_range(0, 3));
      tick($urandom_range(0, 9) != 0, 1'($urandom_range(0, 1)), g);
    end
    idle_cyc(4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule